// File: doc/BRIEF.md
# Configurable Wake Pin Qualifier

This block turns a raw local wake pin into a single-cycle wake event. The pin is synchronized first. A 2-bit mode field then decides what counts as a wake: any edge, only a rising edge, only a falling edge, or a high pulse whose width falls inside a programmable window. A free-running 1 ms tick from outside measures pulse widths. The block keeps no timer of its own.

In pulse mode a pulse is measured in ticks from its leading edge to its trailing edge. It is accepted only if it is at least twice the selected invalid width and no longer than the selected maximum width. A monitor-enable bit hands the pin over to another function. While it is set, no wake is produced and the status output reads low. Each accepted wake also sets a sticky flag, which holds until a clear strobe.

Top module: `wake_qual`

## Requirements
- R1: After reset, `wake_o` and `wake_flag_o` are 0.
- R2: With mode 2'b00 (either edge) and monitor disabled, every rising and every falling transition of the synchronized pin produces exactly one wake event.
- R3: With mode 2'b01, only rising transitions produce a wake event.
- R4: With mode 2'b10, only falling transitions produce a wake event.
- R5: With mode 2'b11 (pulse), a low-high-low pulse of N ticks produces one wake event at its trailing edge when 2*W <= N <= M. W is 5, 10, 20 or 40 for `inv_sel_i` values 0 to 3. M is 750, 1000, 1500 or 2000 for `max_sel_i` values 0 to 3.
- R6: In pulse mode, a pulse of fewer than 2*W ticks produces no event. This covers both widths up to W and widths between W and 2*W.
- R7: In pulse mode, a pulse longer than M ticks produces no event. The width count saturates at 2001.
- R8: While `mon_en_i` is 1, no wake event is produced and `pin_stat_o` is 0.
- R9: While `mon_en_i` is 0, `pin_stat_o` equals the pin level from two clock cycles earlier.
- R10: A wake event sets `wake_flag_o` in the next cycle. The flag stays set until `flag_clr_i` is 1 in a cycle with no wake event; after that cycle it reads 0.
- R11: Each wake event lasts exactly one clock cycle.
- R12: Any change of `mode_i` during a pulse discards the measurement in progress, so that pulse's trailing edge produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw wake pin level |
| tick_1ms_i | input | 1 | One-cycle 1 ms timebase strobe |
| mode_i | input | 2 | Qualification mode |
| mon_en_i | input | 1 | Pin used for monitoring; wake disabled |
| inv_sel_i | input | 2 | Invalid-width select |
| max_sel_i | input | 2 | Maximum-width select |
| flag_clr_i | input | 1 | Clears the sticky wake flag |
| wake_o | output | 1 | Single-cycle wake event |
| pin_stat_o | output | 1 | Live synchronized pin level |
| wake_flag_o | output | 1 | Sticky wake flag |

## Verification
The edge modes are driven with one fixed sequence of rising and falling transitions. Each mode therefore has to count a different subset of the same edges. Pulse mode is tried in two ways. Directed widths sit exactly at the minimum and one tick below it, and at each boundary maximum and one tick above it. Random widths clustered around the thresholds separate the three classes: too short, in between, and accepted. Separate sequences then toggle the monitor bit during pulses, change the mode in the middle of a pulse, and strobe the flag clear.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    WM_ANY   = 2'b00,
    WM_RISE  = 2'b01,
    WM_FALL  = 2'b10,
    WM_PULSE = 2'b11
  } wake_mode_e;

  parameter int CNT_W = 12;

  function automatic logic [CNT_W-1:0] min_width(input logic [1:0] sel);
    logic [CNT_W-1:0] base;
    base = CNT_W'(10);
    return base << sel;
  endfunction

  function automatic logic [CNT_W-1:0] max_width(input logic [1:0] sel);
    logic [CNT_W-1:0] r;
    case (sel)
      2'd0:    r = CNT_W'(750);
      2'd1:    r = CNT_W'(1000);
      2'd2:    r = CNT_W'(1500);
      default: r = CNT_W'(2000);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_edge.sv
module wake_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/wake_width.sv
module wake_width
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       tick_i,
  input  logic [1:0] inv_sel_i,
  input  logic [1:0] max_sel_i,
  output logic       accept_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(2001);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             act_q, act_n;
  logic             ovr_q, ovr_n;
  logic [CNT_W-1:0] lo_w, hi_w;

  assign lo_w = min_width(inv_sel_i);
  assign hi_w = max_width(max_sel_i);

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    ovr_n = ovr_q;
    if (restart_i) begin
      cnt_n = '0;
      act_n = 1'b0;
      ovr_n = 1'b0;
    end else if (rise_i) begin
      cnt_n = '0;
      act_n = 1'b1;
      ovr_n = 1'b0;
    end else if (fall_i) begin
      act_n = 1'b0;
    end else if (act_q) begin
      if (tick_i && (cnt_q < SAT)) cnt_n = cnt_q + 1'b1;
      if (cnt_q > hi_w)            ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
      ovr_q <= ovr_n;
    end
  end

  assign accept_o = fall_i & act_q & ~restart_i & ~ovr_q &
                    (cnt_q >= lo_w) & (cnt_q <= hi_w);
endmodule

// File: rtl/wake_qual.sv
module wake_qual
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       tick_1ms_i,
  input  logic [1:0] mode_i,
  input  logic       mon_en_i,
  input  logic [1:0] inv_sel_i,
  input  logic [1:0] max_sel_i,
  input  logic       flag_clr_i,
  output logic       wake_o,
  output logic       pin_stat_o,
  output logic       wake_flag_o
);
  logic       lvl, rise, fall, accept, restart, edge_hit;
  logic       wake_q, wake_n, flag_q, flag_n;
  logic [1:0] mode_q;
  wake_mode_e mode;

  assign mode = wake_mode_e'(mode_i);

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl)
  );

  wake_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign restart = mon_en_i | (mode != WM_PULSE) | (mode_i != mode_q);

  wake_width u_width (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .rise_i(rise), .fall_i(fall), .tick_i(tick_1ms_i),
    .inv_sel_i(inv_sel_i), .max_sel_i(max_sel_i), .accept_o(accept)
  );

  always_comb begin
    case (mode)
      WM_ANY:  edge_hit = rise | fall;
      WM_RISE: edge_hit = rise;
      WM_FALL: edge_hit = fall;
      default: edge_hit = accept;
    endcase
    wake_n = edge_hit & ~mon_en_i;
    if (wake_q)          flag_n = 1'b1;
    else if (flag_clr_i) flag_n = 1'b0;
    else                 flag_n = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      flag_q <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      wake_q <= wake_n;
      flag_q <= flag_n;
      mode_q <= mode_i;
    end
  end

  assign wake_o      = wake_q;
  assign wake_flag_o = flag_q;
  assign pin_stat_o  = lvl & ~mon_en_i;
endmodule

// File: rtl/wake_qual_chk.sv
module wake_qual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_i,
  input logic       tick_1ms_i,
  input logic [1:0] mode_i,
  input logic       mon_en_i,
  input logic [1:0] inv_sel_i,
  input logic [1:0] max_sel_i,
  input logic       flag_clr_i,
  input logic       wake_o,
  input logic       pin_stat_o,
  input logic       wake_flag_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R8
  mon_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mon_en_i) |-> !wake_o);

  // R8
  mon_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en_i |-> !pin_stat_o);

  // R9
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && !mon_en_i) |-> (pin_stat_o == $past(pin_i, 2)));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> wake_flag_o);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !wake_o) |=> !wake_flag_o);
endmodule

bind wake_qual wake_qual_chk u_chk (.*);

// File: tb/wake_qual_test.sv
module wake_qual_test;
  logic       clk, rst_n, pin, tick, mon, clr;
  logic [1:0] mode, inv, mx;
  logic       wake, stat, flag;

  int compared = 0;
  int mismatched = 0;
  int wake_cnt = 0;
  int run_len = 0;
  int max_run = 0;

  wake_qual uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .tick_1ms_i(tick),
    .mode_i(mode), .mon_en_i(mon), .inv_sel_i(inv), .max_sel_i(mx),
    .flag_clr_i(clr), .wake_o(wake), .pin_stat_o(stat), .wake_flag_o(flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (wake) begin
      wake_cnt++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  function automatic int min_of(input logic [1:0] s);
    return 10 << s;
  endfunction

  function automatic int max_of(input logic [1:0] s);
    case (s)
      2'd0: return 750;
      2'd1: return 1000;
      2'd2: return 1500;
      default: return 2000;
    endcase
  endfunction

  function automatic int exp_pulse(input int n, input logic [1:0] i, input logic [1:0] m);
    return (n >= min_of(i) && n <= max_of(m)) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk) pin = 1'b1;
    cyc(4);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    cyc(2);
    pin = 1'b0;
    cyc(6);
  endtask

  task automatic edge_seq();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) pin = 1'b1;
      cyc(5);
      pin = 1'b0;
      cyc(5);
    end
  endtask

  task automatic pulse_case(input string tag, input logic [1:0] i,
                            input logic [1:0] m, input int n);
    inv = i; mx = m;
    cyc(2);
    wake_cnt = 0;
    pulse(n);
    check(tag, wake_cnt, exp_pulse(n, i, m));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; pin = 0; tick = 0; mon = 0; clr = 0;
    mode = 2'b00; inv = 2'b00; mx = 2'b00;
    cyc(3);
    // R1 reset state
    check("R1 wake", int'(wake), 0);
    check("R1 flag", int'(flag), 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(3);
    check("R1 wake after release", int'(wake), 0);

    // R2, R3, R4: 3 rises and 3 falls per sequence
    mode = 2'b00; cyc(2); wake_cnt = 0; edge_seq();
    check("R2 either edge count", wake_cnt, 6);
    mode = 2'b01; cyc(2); wake_cnt = 0; edge_seq();
    check("R3 rising count", wake_cnt, 3);
    mode = 2'b10; cyc(2); wake_cnt = 0; edge_seq();
    check("R4 falling count", wake_cnt, 3);
    // R11: events one cycle wide
    check("R11 event width", max_run, 1);

    // R10 sticky flag and clear
    check("R10 flag set", int'(flag), 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R10 flag cleared", int'(flag), 0);

    // R9 status follows pin
    @(negedge clk) pin = 1'b1;
    cyc(3);
    check("R9 stat high", int'(stat), 1);
    pin = 1'b0;
    cyc(3);
    check("R9 stat low", int'(stat), 0);

    // R8 monitor enabled: no events, status low
    mode = 2'b00; mon = 1'b1; cyc(2); wake_cnt = 0;
    @(negedge clk) pin = 1'b1;
    cyc(4);
    check("R8 stat masked", int'(stat), 0);
    pin = 1'b0;
    cyc(4);
    check("R8 no edge event", wake_cnt, 0);
    mode = 2'b11; cyc(2); wake_cnt = 0;
    pulse(15);
    check("R8 no pulse event", wake_cnt, 0);
    mon = 1'b0; cyc(2);

    // R5 / R6 directed boundaries
    mode = 2'b11;
    pulse_case("R5 min width inv0", 2'd0, 2'd0, 10);
    pulse_case("R6 below min inv0", 2'd0, 2'd0, 9);
    pulse_case("R6 at invalid inv0", 2'd0, 2'd0, 5);
    pulse_case("R5 min width inv3", 2'd3, 2'd0, 80);
    pulse_case("R6 between inv3", 2'd3, 2'd0, 60);
    // R7 max boundaries
    pulse_case("R5 at max 750", 2'd0, 2'd0, 750);
    pulse_case("R7 over max 750", 2'd0, 2'd0, 751);
    pulse_case("R5 at max 2000", 2'd1, 2'd3, 2000);
    pulse_case("R7 over max 2000", 2'd1, 2'd3, 2001);
    pulse_case("R7 saturated", 2'd1, 2'd3, 2010);

    // R12 mode change during pulse
    inv = 2'd0; mx = 2'd0; cyc(2); wake_cnt = 0;
    @(negedge clk) pin = 1'b1;
    cyc(4);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    mode = 2'b01; cyc(2); mode = 2'b11; cyc(2);
    pin = 1'b0;
    cyc(6);
    check("R12 aborted pulse", wake_cnt, 0);

    // R5 / R6 constrained random around thresholds
    for (int t = 0; t < 24; t++) begin
      logic [1:0] ri, rm;
      int n, pick;
      ri = 2'($urandom_range(0, 3));
      rm = 2'($urandom_range(0, 3));
      pick = $urandom_range(0, 4);
      case (pick)
        0: n = min_of(ri) - 1;
        1: n = min_of(ri);
        2: n = (10 << ri) / 2;
        3: n = min_of(ri) + $urandom_range(1, 20);
        default: n = $urandom_range(1, 90);
      endcase
      pulse_case(exp_pulse(n, ri, rm) != 0 ? "R5 random accept" : "R6 random reject",
                 ri, rm, n);
    end
    check("R11 event width final", max_run, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule